// File: doc/BRIEF.md
# Performance Monitor Counter Unit

This block holds six 32-bit event counters and two configuration registers: a control register and an event-select register. On every clock the unit receives the number of instructions that completed in that cycle and a run-latch level. It works out whether each counter counts instructions, counts clock cycles or stays idle. It then applies the freeze controls and advances the counters. Counters 1 to 4 take their event from an 8-bit selector. Counter 5 always counts instructions and counter 6 always counts cycles. A counter that reaches the sign boundary while its condition enable is set is held at that boundary. The overflow can freeze the whole unit and turn a pending alert enable into a recorded alert. The unit then drives a one-cycle exception pulse.

Software reaches every register through a single address/data port. Writes take effect on the clock edge. Reads are combinational on the same address. The control path holds a two-state exception machine. EXC_QUIET is the idle state. It moves to EXC_RAISE on any clock edge where some counter overflows. EXC_RAISE drives the exception output. It stays in EXC_RAISE when another overflow happens on the next edge, and otherwise returns to EXC_QUIET.

Top module: `perf_counter_unit`

## Requirements
- R1: While reset is asserted and right after it, every counter, the control register and the event-select register read zero, and the exception output is low.
- R2: Register addresses are 0 for control, 1 for event select and 2 to 7 for counters 1 to 6. Reads are combinational. A write to a counter in a cycle where that counter would also advance stores the written value and drops the increment.
- R3: The selector for counter 1 is bits 7:0 of the event register. Counter 1 counts instructions for codes 0x02 and 0xFE and counts cycles for codes 0x1E and 0xF0.
- R4: The selectors for counters 2 and 3 are bits 15:8 and bits 23:16. Each counts instructions for 0x02 and cycles for 0x1E. Every other code, 0xFE and 0xF0 included, leaves it idle.
- R5: The selector for counter 4 is bits 31:24. Counter 4 counts instructions for 0x02, and counts cycles for 0x1E. For 0xFA it counts instructions only in cycles where the run-latch input is high.
- R6: Counter 5 adds the instruction count on every cycle and counter 6 adds one on every cycle, unless control bit 2 (freeze 5/6) is set.
- R7: Control bit 0 (global freeze) stops all six counters. Control bit 1 stops counters 1 to 4 only. Counters 1 to 4 are also stopped while the event register is all zero.
- R8: A counter overflows when it is counting or being written, its value after the update is at least 0x8000_0000, and its enable is set. Counter 1 uses control bit 3 and counters 2 to 6 use control bit 4. An overflowing counter is loaded with exactly 0x8000_0000. With the enable clear the counter runs on past that value.
- R9: On an overflow, if control bit 5 (freeze on condition) is set, it is cleared and bit 0 is set. If bit 6 (alert enable) is set, it is cleared and bit 7 (alert seen) is set. A software write to the control register in the same cycle overrides both updates.
- R10: The exception output is high during the cycle that follows each clock edge at which at least one counter overflowed. Several counters overflowing together give one pulse. An instruction counter that receives a zero count is not tested for overflow.
- R11: The instruction count is added in a single step, so one update can jump past 0x8000_0000 and still clamp.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| insn_done | input | INS_W | Instructions completed this cycle |
| run_latch | input | 1 | Run-latch level that gates counter 4 on code 0xFA |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register address for read and write |
| wr_data | input | CNT_W | Register write data |
| rd_data | output | CNT_W | Combinational read data |
| pm_exc | output | 1 | Performance-monitor exception pulse |

## Verification
The hardest case to reach is a counter that is near the sign boundary at the exact moment it starts counting. Getting there needs a preset value close to 0x8000_0000 while the unit is frozen, with the chosen enables and event codes already loaded. The bench does each setup under global freeze. It writes the final control value in a cycle that still uses the frozen settings, so the first counting cycle is known exactly. From there it drives a jump across the boundary, two counters crossing together, a write above the boundary, and a control write colliding with an overflow.

// File: rtl/pcu_pkg.sv
package pcu_pkg;

    localparam int NUM_CNT = 6;
    localparam int NUM_SEL = 4;
    localparam int SEL_W   = 8;
    localparam int EVT_W   = NUM_SEL * SEL_W;
    localparam int CTRL_W  = 8;
    localparam int ADDR_W  = 3;

    // control register bit positions
    localparam int B_FRZ_ALL   = 0;
    localparam int B_FRZ_LO    = 1;
    localparam int B_FRZ_HI    = 2;
    localparam int B_CE_FIRST  = 3;
    localparam int B_CE_REST   = 4;
    localparam int B_FRZ_ON_CE = 5;
    localparam int B_ALERT_EN  = 6;
    localparam int B_ALERT_HIT = 7;

    localparam logic [ADDR_W-1:0] A_CTRL     = 3'd0;
    localparam logic [ADDR_W-1:0] A_EVT      = 3'd1;
    localparam logic [ADDR_W-1:0] A_CNT_BASE = 3'd2;

    localparam logic [SEL_W-1:0] EV_INSN      = 8'h02;
    localparam logic [SEL_W-1:0] EV_CYC       = 8'h1E;
    localparam logic [SEL_W-1:0] EV_INSN_ALT1 = 8'hFE;
    localparam logic [SEL_W-1:0] EV_CYC_ALT1  = 8'hF0;
    localparam logic [SEL_W-1:0] EV_INSN_RUN4 = 8'hFA;

    typedef enum logic [1:0] {
        MODE_IDLE,
        MODE_INSN,
        MODE_CYCLE
    } cnt_mode_t;

    typedef enum logic {
        EXC_QUIET,
        EXC_RAISE
    } exc_state_t;

endpackage

// File: rtl/pcu_event_decode.sv
module pcu_event_decode
    import pcu_pkg::*;
#(
    parameter int IDX = 0
) (
    input  logic [SEL_W-1:0] sel,
    input  logic             evt_nz,
    input  logic             frz_all,
    input  logic             frz_lo,
    input  logic             run_latch,
    output cnt_mode_t        mode
);

    cnt_mode_t raw;
    logic      needs_run;

    generate
        if (IDX == 0) begin : g_first
            assign needs_run = 1'b0;
            always_comb begin
                case (sel)
                    EV_INSN, EV_INSN_ALT1: raw = MODE_INSN;
                    EV_CYC,  EV_CYC_ALT1:  raw = MODE_CYCLE;
                    default:               raw = MODE_IDLE;
                endcase
            end
        end else if (IDX < NUM_SEL - 1) begin : g_mid
            assign needs_run = 1'b0;
            always_comb begin
                case (sel)
                    EV_INSN: raw = MODE_INSN;
                    EV_CYC:  raw = MODE_CYCLE;
                    default: raw = MODE_IDLE;
                endcase
            end
        end else begin : g_last
            assign needs_run = (sel == EV_INSN_RUN4);
            always_comb begin
                case (sel)
                    EV_INSN, EV_INSN_RUN4: raw = MODE_INSN;
                    EV_CYC:                raw = MODE_CYCLE;
                    default:               raw = MODE_IDLE;
                endcase
            end
        end
    endgenerate

    always_comb begin
        if (frz_all || frz_lo || !evt_nz) begin
            mode = MODE_IDLE;
        end else if (needs_run && !run_latch) begin
            mode = MODE_IDLE;
        end else begin
            mode = raw;
        end
    end

endmodule

// File: rtl/pcu_counter.sv
module pcu_counter
    import pcu_pkg::*;
#(
    parameter int CNT_W = 32,
    parameter int INS_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  cnt_mode_t        mode,
    input  logic [INS_W-1:0] ins,
    input  logic             wr_hit,
    input  logic [CNT_W-1:0] wr_data,
    input  logic             cond_en,
    output logic [CNT_W-1:0] cnt_q,
    output logic             ovf
);

    localparam logic [CNT_W-1:0] THRESH = {1'b1, {(CNT_W-1){1'b0}}};

    logic [CNT_W-1:0] base;
    logic [CNT_W-1:0] cnt_d;
    logic             checked;

    always_comb begin
        checked = 1'b0;
        base    = cnt_q;
        if (wr_hit) begin
            base    = wr_data;
            checked = (mode != MODE_IDLE);
        end else begin
            case (mode)
                MODE_INSN: begin
                    base    = cnt_q + CNT_W'(ins);
                    checked = (ins != '0);
                end
                MODE_CYCLE: begin
                    base    = cnt_q + CNT_W'(1);
                    checked = 1'b1;
                end
                default: begin
                    base    = cnt_q;
                    checked = 1'b0;
                end
            endcase
        end
        ovf   = checked && cond_en && (base >= THRESH);
        cnt_d = ovf ? THRESH : base;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

endmodule

// File: rtl/pcu_ctrl.sv
module pcu_ctrl
    import pcu_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctrl_wr,
    input  logic              evt_wr,
    input  logic [EVT_W-1:0]  wr_data,
    input  logic              any_ovf,
    output logic [CTRL_W-1:0] ctrl_q,
    output logic [EVT_W-1:0]  evt_q,
    output logic              pm_exc
);

    logic [CTRL_W-1:0] ctrl_d;
    exc_state_t        state_q;
    exc_state_t        state_d;

    always_comb begin
        ctrl_d = ctrl_q;
        if (ctrl_wr) begin
            ctrl_d = wr_data[CTRL_W-1:0];
        end else if (any_ovf) begin
            if (ctrl_q[B_FRZ_ON_CE]) begin
                ctrl_d[B_FRZ_ON_CE] = 1'b0;
                ctrl_d[B_FRZ_ALL]   = 1'b1;
            end
            if (ctrl_q[B_ALERT_EN]) begin
                ctrl_d[B_ALERT_EN]  = 1'b0;
                ctrl_d[B_ALERT_HIT] = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= '0;
            evt_q  <= '0;
        end else begin
            ctrl_q <= ctrl_d;
            if (evt_wr) begin
                evt_q <= wr_data;
            end
        end
    end

    // exception state machine: next-state logic
    always_comb begin
        unique case (state_q)
            EXC_QUIET: state_d = any_ovf ? EXC_RAISE : EXC_QUIET;
            EXC_RAISE: state_d = any_ovf ? EXC_RAISE : EXC_QUIET;
            default:   state_d = EXC_QUIET;
        endcase
    end

    // exception state machine: state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= EXC_QUIET;
        end else begin
            state_q <= state_d;
        end
    end

    // exception state machine: outputs
    always_comb begin
        unique case (state_q)
            EXC_RAISE: pm_exc = 1'b1;
            default:   pm_exc = 1'b0;
        endcase
    end

endmodule

// File: rtl/perf_counter_unit.sv
module perf_counter_unit
    import pcu_pkg::*;
#(
    parameter int CNT_W = 32,
    parameter int INS_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [INS_W-1:0]  insn_done,
    input  logic              run_latch,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [CNT_W-1:0]  wr_data,
    output logic [CNT_W-1:0]  rd_data,
    output logic              pm_exc
);

    logic [CTRL_W-1:0]             ctrl_q;
    logic [EVT_W-1:0]              evt_q;
    logic [NUM_CNT-1:0][CNT_W-1:0] cnt_q;
    logic [NUM_CNT-1:0]            ovf_vec;
    cnt_mode_t                     mode [NUM_CNT];
    logic                          any_ovf;
    logic                          ctrl_wr;
    logic                          evt_wr;
    logic                          evt_nz;

    assign ctrl_wr = wr_en && (addr == A_CTRL);
    assign evt_wr  = wr_en && (addr == A_EVT);
    assign evt_nz  = (evt_q != '0);
    assign any_ovf = |ovf_vec;

    pcu_ctrl u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .ctrl_wr (ctrl_wr),
        .evt_wr  (evt_wr),
        .wr_data (wr_data[EVT_W-1:0]),
        .any_ovf (any_ovf),
        .ctrl_q  (ctrl_q),
        .evt_q   (evt_q),
        .pm_exc  (pm_exc)
    );

    generate
        for (genvar i = 0; i < NUM_CNT; i++) begin : g_cnt
            localparam logic [ADDR_W-1:0] MY_ADDR = A_CNT_BASE + ADDR_W'(i);
            logic cond_en;

            if (i < NUM_SEL) begin : g_sel
                pcu_event_decode #(.IDX(i)) u_dec (
                    .sel       (evt_q[i*SEL_W +: SEL_W]),
                    .evt_nz    (evt_nz),
                    .frz_all   (ctrl_q[B_FRZ_ALL]),
                    .frz_lo    (ctrl_q[B_FRZ_LO]),
                    .run_latch (run_latch),
                    .mode      (mode[i])
                );
            end else begin : g_fixed
                localparam cnt_mode_t FIXED = (i == NUM_SEL) ? MODE_INSN : MODE_CYCLE;
                assign mode[i] = (ctrl_q[B_FRZ_ALL] || ctrl_q[B_FRZ_HI]) ? MODE_IDLE : FIXED;
            end

            if (i == 0) begin : g_ce_first
                assign cond_en = ctrl_q[B_CE_FIRST];
            end else begin : g_ce_rest
                assign cond_en = ctrl_q[B_CE_REST];
            end

            pcu_counter #(.CNT_W(CNT_W), .INS_W(INS_W)) u_counter (
                .clk     (clk),
                .rst_n   (rst_n),
                .mode    (mode[i]),
                .ins     (insn_done),
                .wr_hit  (wr_en && (addr == MY_ADDR)),
                .wr_data (wr_data),
                .cond_en (cond_en),
                .cnt_q   (cnt_q[i]),
                .ovf     (ovf_vec[i])
            );
        end
    endgenerate

    always_comb begin
        rd_data = '0;
        if (addr == A_CTRL) begin
            rd_data = CNT_W'(ctrl_q);
        end else if (addr == A_EVT) begin
            rd_data = CNT_W'(evt_q);
        end else begin
            for (int k = 0; k < NUM_CNT; k++) begin
                if (addr == A_CNT_BASE + ADDR_W'(k)) begin
                    rd_data = cnt_q[k];
                end
            end
        end
    end

endmodule

// File: rtl/pcu_checker.sv
module pcu_checker
    import pcu_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input logic                          clk,
    input logic                          rst_n,
    input logic                          wr_en,
    input logic [ADDR_W-1:0]             addr,
    input logic [CTRL_W-1:0]             ctrl_q,
    input logic [NUM_CNT-1:0]            ovf_vec,
    input logic [NUM_CNT-1:0][CNT_W-1:0] cnt_q,
    input logic                          pm_exc
);

    localparam logic [CNT_W-1:0] THRESH = {1'b1, {(CNT_W-1){1'b0}}};

    logic ctrl_wr;
    assign ctrl_wr = wr_en && (addr == A_CTRL);

    // R10: a pulse follows every overflow edge
    a_r10_pulse_after_ovf: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_vec != '0) |=> pm_exc);

    // R10: no pulse without an overflow
    a_r10_no_spurious_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_vec == '0) |=> !pm_exc);

    // R8: counter 1 lands exactly on the boundary
    a_r8_clamp_first: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_vec[0] |=> (cnt_q[0] == THRESH));

    // R9: freeze on condition converts into global freeze
    a_r9_freeze_on_cond: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_vec != '0 && ctrl_q[B_FRZ_ON_CE] && !ctrl_wr)
        |=> (ctrl_q[B_FRZ_ALL] && !ctrl_q[B_FRZ_ON_CE]));

    // R9: alert enable converts into alert seen
    a_r9_alert_convert: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_vec != '0 && ctrl_q[B_ALERT_EN] && !ctrl_wr)
        |=> (ctrl_q[B_ALERT_HIT] && !ctrl_q[B_ALERT_EN]));

    generate
        for (genvar i = 0; i < NUM_CNT; i++) begin : g_frz
            // R7: global freeze holds every counter not being written
            a_r7_global_freeze: assert property (@(posedge clk) disable iff (!rst_n)
                (ctrl_q[B_FRZ_ALL] && !wr_en) |=> $stable(cnt_q[i]));
        end
    endgenerate

endmodule

bind perf_counter_unit pcu_checker #(.CNT_W(CNT_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .addr    (addr),
    .ctrl_q  (ctrl_q),
    .ovf_vec (ovf_vec),
    .cnt_q   (cnt_q),
    .pm_exc  (pm_exc)
);

// File: tb/perf_counter_unit_test.sv
module perf_counter_unit_test;

    localparam int CLK_PERIOD = 20;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  insn_done = '0;
    logic        run_latch = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  addr = '0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic        pm_exc;

    int checks = 0;
    int errors = 0;

    perf_counter_unit uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .insn_done (insn_done),
        .run_latch (run_latch),
        .wr_en     (wr_en),
        .addr      (addr),
        .wr_data   (wr_data),
        .rd_data   (rd_data),
        .pm_exc    (pm_exc)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    typedef struct packed {
        logic [7:0]       ctrl;
        logic [31:0]      evt;
        logic [2:0]       ins;
        logic             run;
        logic [5:0][31:0] exp;   // {c6,c5,c4,c3,c2,c1} after four cycles
    } vec_t;

    // R3 R4 R5 R6 R7 coverage through the table
    localparam vec_t VECS [9] = '{
        '{8'h00, 32'h1E1E0202, 3'd3, 1'b0, {32'd4, 32'd12, 32'd4,  32'd4,  32'd12, 32'd12}},
        '{8'h00, 32'hFA02F0FE, 3'd2, 1'b1, {32'd4, 32'd8,  32'd8,  32'd8,  32'd0,  32'd8}},
        '{8'h00, 32'hFA1E02F0, 3'd1, 1'b0, {32'd4, 32'd4,  32'd0,  32'd4,  32'd4,  32'd4}},
        '{8'h02, 32'h02020202, 3'd5, 1'b0, {32'd4, 32'd20, 32'd0,  32'd0,  32'd0,  32'd0}},
        '{8'h04, 32'h02020202, 3'd5, 1'b0, {32'd0, 32'd0,  32'd20, 32'd20, 32'd20, 32'd20}},
        '{8'h00, 32'h00000000, 3'd7, 1'b0, {32'd4, 32'd28, 32'd0,  32'd0,  32'd0,  32'd0}},
        '{8'h00, 32'h021EFE1E, 3'd6, 1'b0, {32'd4, 32'd24, 32'd24, 32'd4,  32'd0,  32'd4}},
        '{8'h00, 32'hF0FAFA33, 3'd4, 1'b0, {32'd4, 32'd16, 32'd0,  32'd0,  32'd0,  32'd0}},
        '{8'h00, 32'hFA000000, 3'd3, 1'b1, {32'd4, 32'd12, 32'd12, 32'd0,  32'd0,  32'd0}}
    };

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        addr    = a;
        wr_data = d;
        wr_en   = 1'b1;
        tick();
        wr_en   = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] v);
        addr = a;
        #1;
        v = rd_data;
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic chk_reg(input string tag, input logic [2:0] a, input logic [31:0] exp);
        logic [31:0] v;
        rd(a, v);
        chk(tag, v, exp);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        errors++;
        $display("FAIL R1 watchdog: actual=timeout expected=completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] v;

        // R1: reset state
        repeat (2) @(posedge clk);
        #1;
        for (int a = 0; a < 8; a++) begin
            rd(3'(a), v);
            chk($sformatf("R1 reset reg %0d", a), v, 32'h0);
        end
        chk("R1 reset exception", {31'b0, pm_exc}, 32'h0);
        rst_n = 1'b1;
        tick();

        // table walk
        for (int n = 0; n < 9; n++) begin
            insn_done = '0;
            run_latch = 1'b0;
            wr(3'd0, 32'h1);
            wr(3'd1, VECS[n].evt);
            for (int a = 2; a < 8; a++) wr(3'(a), 32'h0);
            wr(3'd0, {24'h0, VECS[n].ctrl});
            insn_done = VECS[n].ins;
            run_latch = VECS[n].run;
            repeat (4) tick();
            for (int c = 0; c < 6; c++) begin
                rd(3'(c + 2), v);
                chk($sformatf("R3 R4 R5 R6 R7 vector %0d counter %0d", n, c + 1), v, VECS[n].exp[c]);
            end
        end

        // R7: global freeze holds everything
        insn_done = '0;
        wr(3'd0, 32'h1);
        wr(3'd1, 32'h02020202);
        for (int a = 2; a < 8; a++) wr(3'(a), 32'd100);
        insn_done = 3'd7;
        run_latch = 1'b1;
        repeat (3) tick();
        for (int a = 2; a < 8; a++) chk_reg($sformatf("R7 global freeze counter %0d", a - 1), 3'(a), 32'd100);

        // R2: write beats increment
        insn_done = 3'd3;
        wr(3'd0, 32'h0);
        wr(3'd3, 32'd500);
        chk_reg("R2 write priority counter 2", 3'd3, 32'd500);
        chk_reg("R2 neighbour counter 1 counts", 3'd2, 32'd103);

        // R11 R8 R9 R10: single-step jump past boundary with freeze and alert
        insn_done = '0;
        wr(3'd0, 32'h1);
        wr(3'd1, 32'h00000002);
        wr(3'd2, 32'h7FFFFFFE);
        wr(3'd6, 32'h0);
        wr(3'd7, 32'h0);
        wr(3'd0, 32'h68);
        insn_done = 3'd5;
        tick();
        chk("R10 pulse on overflow", {31'b0, pm_exc}, 32'h1);
        chk_reg("R11 jump clamps counter 1", 3'd2, 32'h80000000);
        chk_reg("R9 freeze and alert conversion", 3'd0, 32'h89);
        insn_done = '0;
        tick();
        chk("R10 pulse lasts one cycle", {31'b0, pm_exc}, 32'h0);
        chk_reg("R7 counter 1 frozen after overflow", 3'd2, 32'h80000000);

        // R8: enable clear lets counter run past boundary
        wr(3'd1, 32'h0000001E);
        wr(3'd2, 32'h7FFFFFFF);
        wr(3'd0, 32'h0);
        tick();
        chk_reg("R8 no clamp without enable", 3'd2, 32'h80000000);
        chk("R8 no pulse without enable", {31'b0, pm_exc}, 32'h0);
        tick();
        chk_reg("R8 counter passes boundary", 3'd2, 32'h80000001);

        // R10: two counters overflow together, shared enable
        wr(3'd0, 32'h1);
        wr(3'd1, 32'h00020200);
        wr(3'd3, 32'h7FFFFFFF);
        wr(3'd4, 32'h7FFFFFFF);
        wr(3'd6, 32'h0);
        wr(3'd7, 32'h0);
        wr(3'd0, 32'h10);
        insn_done = 3'd1;
        tick();
        chk("R10 one pulse for two counters", {31'b0, pm_exc}, 32'h1);
        chk_reg("R8 counter 2 clamp", 3'd3, 32'h80000000);
        chk_reg("R8 counter 3 clamp", 3'd4, 32'h80000000);
        chk_reg("R9 control untouched without bits", 3'd0, 32'h10);
        insn_done = '0;
        tick();
        chk("R10 zero count is not tested", {31'b0, pm_exc}, 32'h0);

        // R8 R2: write above boundary on a counting counter
        wr(3'd4, 32'h90000000);
        chk_reg("R8 written value clamps", 3'd4, 32'h80000000);
        chk("R8 written overflow pulses", {31'b0, pm_exc}, 32'h1);

        // R9: control write collides with overflow
        wr(3'd0, 32'h1);
        wr(3'd1, 32'h00000002);
        wr(3'd2, 32'h7FFFFFFF);
        wr(3'd0, 32'h48);
        insn_done = 3'd1;
        wr(3'd0, 32'h48);
        insn_done = '0;
        chk_reg("R9 control write wins", 3'd0, 32'h48);
        chk_reg("R8 clamp during control write", 3'd2, 32'h80000000);
        chk("R10 pulse during control write", {31'b0, pm_exc}, 32'h1);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule